// File: doc/BRIEF.md
# Binary64 Floating-Point Adder/Subtractor

This block adds or subtracts two IEEE-754 binary floating-point numbers. It is built for the 64-bit interchange format by default. Exponent and fraction widths are parameters, so a narrow copy of the same datapath can be built. Each operand is split into sign, exponent and significand. The operand with the larger exponent takes the "big" slot, and the other significand is shifted right by the exponent gap. Bits shifted past the rounding position are folded into a sticky bit.

The significands are then added or subtracted according to the effective operation, which is the two signs combined with the subtract select. The sum is normalized in one of two ways. A carry out of the top bit causes a one-bit right shift. A cancellation is handled by counting leading zeros and shifting left. The normalized value is rounded to nearest, ties to even, and the packed word is registered.

Special operands follow fixed rules instead of the arithmetic path. A NaN on either input gives a quiet NaN. An infinity passes through, except that infinity minus infinity gives a quiet NaN. An operand with a zero exponent field, meaning a zero or a subnormal, is treated as a signed zero. A result that runs out of exponent range becomes a signed infinity and raises an overflow flag. A result that falls below the normal range becomes a signed zero.

Top module: `fp_addsub`

## Requirements
- R1: With both operands normal and the effective operation an addition, `result` is the exact sum rounded to nearest, ties to even.
- R2: With an effective subtraction, the result carries the sign of the true difference, even when equal exponents put the smaller magnitude in the big slot; an exact cancellation gives +0 (all bits zero).
- R3: An exponent gap of any size, including gaps wider than the significand, shifts the smaller significand into guard, round and sticky positions, so the rounding stays correct (for example 1.0 plus a tiny value returns 1.0).
- R4: A carry out of the significand sum increments the exponent, and the bit shifted out at the low end takes part in rounding (ties still go to even).
- R5: A NaN on either input, or the sum of two infinities of opposite effective sign, gives the quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0.
- R6: A single infinite operand is passed through with its effective sign. A finite sum whose rounded exponent reaches all ones becomes an infinity (exponent all ones, fraction 0) with the result sign, and `ovf` is 1 for that result; otherwise `ovf` is 0.
- R7: An operand whose exponent field is 0 counts as a zero. If only one operand is zero, the result is the other operand with its effective sign (operand B's sign is inverted when `sub` is 1). If both are zero, the result is -0 only when both effective signs are negative, and +0 otherwise.
- R8: A nonzero result whose normalized exponent would fall below 1 is returned as a zero with the result sign.
- R9: `result` and `ovf` update only on a clock edge where `en` is 1. `valid` is 1 in the cycle after an edge with `en` at 1, and 0 after an edge with `en` at 0.
- R10: Reset is synchronous and active high; it clears `result`, `valid` and `ovf` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accepts the operands on this edge |
| sub | input | 1 | 1 computes op_a minus op_b, 0 computes op_a plus op_b |
| op_a | input | 1+EXP_W+FRAC_W (64) | First operand |
| op_b | input | 1+EXP_W+FRAC_W (64) | Second operand |
| result | output | 1+EXP_W+FRAC_W (64) | Registered rounded result |
| valid | output | 1 | Result register was loaded on the previous edge |
| ovf | output | 1 | Registered result is an infinity produced from finite operands |

## Verification
A narrow copy of the block, with a 4-bit exponent and a 3-bit fraction, is driven with every pair of 8-bit operands under both add and subtract. Each result is compared against exact integer arithmetic followed by a separate ties-to-even rounding model. This sweep covers every alignment distance, every cancellation depth, the carry and rounding-carry cases, and all special-value combinations, which separates the normalization and rounding paths.

The full 64-bit copy gets directed operand pairs whose expected values come from the simulator's own double arithmetic. These pairs exercise:
- exact ties, and ties broken by a distant sticky bit
- gaps far wider than the significand
- a carry with a dropped bit
- overflow from the largest finite values

Further sequences hold `en` low and assert reset between operations. They check that the register contents and `valid` follow R9 and R10.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Operand class after unpacking; subnormals fold into the zero class.
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fcls_e;

endpackage

// File: rtl/fpa_classify.sv
module fpa_classify
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int TOT   = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [TOT-1:0]   word,
    input  logic             flip,
    output logic             sgn,
    output logic [EXP_W-1:0] expo,
    output logic [SIG_W-1:0] sig,
    output fcls_e            cls
);
    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_nil;

    always_comb begin
        sgn     = word[TOT-1] ^ flip;
        expo    = word[TOT-2:FRAC_W];
        frac    = word[FRAC_W-1:0];
        exp_max = &expo;
        exp_nil = (expo == '0);
        sig     = {1'b1, frac};
        if (exp_max && (frac != '0))
            cls = CLS_NAN;
        else if (exp_max)
            cls = CLS_INF;
        else if (exp_nil)
            cls = CLS_ZERO;
        else
            cls = CLS_NORM;
    end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int SIG_W = FRAC_W + 1,
    localparam int W     = SIG_W + 3
) (
    input  logic             a_sgn,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sgn,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output logic             big_sgn,
    output logic             small_sgn,
    output logic [EXP_W-1:0] big_exp,
    output logic [W-1:0]     big_w,
    output logic [W-1:0]     small_w
);
    logic             swap;
    logic [EXP_W-1:0] small_exp;
    logic [EXP_W-1:0] gap;
    logic [W-1:0]     ext;
    logic [W-1:0]     shifted;
    logic             lost;

    always_comb begin
        // ordering looks at exponents only; equal exponents keep A as big
        swap      = (b_exp > a_exp);
        big_sgn   = swap ? b_sgn : a_sgn;
        small_sgn = swap ? a_sgn : b_sgn;
        big_exp   = swap ? b_exp : a_exp;
        small_exp = swap ? a_exp : b_exp;
        big_w     = {(swap ? b_sig : a_sig), 3'b000};
        ext       = {(swap ? a_sig : b_sig), 3'b000};
        gap       = big_exp - small_exp;
        shifted   = ext >> gap;
        lost      = |(ext & ~({W{1'b1}} << gap));
        small_w   = {shifted[W-1:1], shifted[0] | lost};
    end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
    parameter int W  = 56,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int XW     = 19,
    localparam int TOT   = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1,
    localparam int W     = SIG_W + 3
) (
    input  logic                 sgn,
    input  logic signed [XW-1:0] exp_n,
    input  logic [W-1:0]         norm,
    output logic [TOT-1:0]       word,
    output logic                 ovf
);
    localparam logic signed [XW-1:0] EMAX = XW'((1 << EXP_W) - 1);

    logic [SIG_W-1:0]     sig;
    logic                 grd;
    logic                 rs;
    logic                 inc;
    logic [SIG_W:0]       rsum;
    logic signed [XW-1:0] e_fin;

    always_comb begin
        sig   = norm[W-1:3];
        grd   = norm[2];
        rs    = |norm[1:0];
        inc   = grd & (rs | sig[0]);
        rsum  = {1'b0, sig} + {{SIG_W{1'b0}}, inc};
        e_fin = exp_n + XW'(rsum[SIG_W]);
        ovf   = 1'b0;
        if (exp_n < XW'(1)) begin
            word = {sgn, {(TOT-1){1'b0}}};
        end else if (e_fin >= EMAX) begin
            word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf  = 1'b1;
        end else begin
            // on a rounding carry the fraction field is all zeros either way
            word = {sgn, e_fin[EXP_W-1:0], rsum[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int TOT   = 1 + EXP_W + FRAC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           sub,
    input  logic [TOT-1:0] op_a,
    input  logic [TOT-1:0] op_b,
    output logic [TOT-1:0] result,
    output logic           valid,
    output logic           ovf
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int W     = SIG_W + 3;
    localparam int CW    = $clog2(W + 1);
    localparam int XW    = EXP_W + CW + 2;
    localparam logic [TOT-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic [TOT-1:0] res;
        logic           vld;
        logic           ovf;
    } state_t;

    state_t st_d, st_q;

    // unpack
    logic             a_sgn, b_sgn;
    logic [EXP_W-1:0] a_exp, b_exp;
    logic [SIG_W-1:0] a_sig, b_sig;
    fcls_e            a_cls, b_cls;
    logic [TOT-1:0]   b_eff;

    fpa_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .word(op_a), .flip(1'b0),
        .sgn(a_sgn), .expo(a_exp), .sig(a_sig), .cls(a_cls)
    );
    fpa_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .word(op_b), .flip(sub),
        .sgn(b_sgn), .expo(b_exp), .sig(b_sig), .cls(b_cls)
    );

    // align
    logic             big_sgn, small_sgn;
    logic [EXP_W-1:0] big_exp;
    logic [W-1:0]     big_w, small_w;

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .a_sgn(a_sgn), .a_exp(a_exp), .a_sig(a_sig),
        .b_sgn(b_sgn), .b_exp(b_exp), .b_sig(b_sig),
        .big_sgn(big_sgn), .small_sgn(small_sgn), .big_exp(big_exp),
        .big_w(big_w), .small_w(small_w)
    );

    // significand add / subtract
    logic                 eff_sub;
    logic [W:0]           sum_w;
    logic [W:0]           dif_w;
    logic                 dif_neg;
    logic [W-1:0]         dif_mag;
    logic [CW-1:0]        lz;
    logic                 cancel;
    logic [W-1:0]         norm;
    logic signed [XW-1:0] exp_n;
    logic signed [XW-1:0] big_x;
    logic                 r_sgn;

    always_comb begin
        eff_sub = big_sgn ^ small_sgn;
        sum_w   = {1'b0, big_w} + {1'b0, small_w};
        dif_w   = {1'b0, big_w} - {1'b0, small_w};
        dif_neg = dif_w[W];
        dif_mag = dif_neg ? (~dif_w[W-1:0] + W'(1)) : dif_w[W-1:0];
        cancel  = eff_sub && (dif_mag == '0);
    end

    fpa_lzc #(.W(W)) u_lzc (
        .vec(dif_mag), .cnt(lz)
    );

    always_comb begin
        big_x = {{(XW-EXP_W){1'b0}}, big_exp};
        if (!eff_sub) begin
            r_sgn = big_sgn;
            if (sum_w[W]) begin
                norm  = {sum_w[W:2], sum_w[1] | sum_w[0]};
                exp_n = big_x + XW'(1);
            end else begin
                norm  = sum_w[W-1:0];
                exp_n = big_x;
            end
        end else begin
            r_sgn = big_sgn ^ dif_neg;
            norm  = dif_mag << lz;
            exp_n = big_x - {{(XW-CW){1'b0}}, lz};
        end
    end

    // round and pack
    logic [TOT-1:0] rnd_word;
    logic           rnd_ovf;

    fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_round (
        .sgn(r_sgn), .exp_n(exp_n), .norm(norm),
        .word(rnd_word), .ovf(rnd_ovf)
    );

    // next state
    always_comb begin
        b_eff = {op_b[TOT-1] ^ sub, op_b[TOT-2:0]};
        st_d  = st_q;
        if (en) begin
            st_d.vld = 1'b1;
            st_d.ovf = 1'b0;
            if (a_cls == CLS_NAN || b_cls == CLS_NAN) begin
                st_d.res = QNAN;
            end else if (a_cls == CLS_INF && b_cls == CLS_INF) begin
                st_d.res = (a_sgn != b_sgn) ? QNAN : op_a;
            end else if (a_cls == CLS_INF) begin
                st_d.res = op_a;
            end else if (b_cls == CLS_INF) begin
                st_d.res = b_eff;
            end else if (a_cls == CLS_ZERO && b_cls == CLS_ZERO) begin
                st_d.res = {a_sgn & b_sgn, {(TOT-1){1'b0}}};
            end else if (a_cls == CLS_ZERO) begin
                st_d.res = b_eff;
            end else if (b_cls == CLS_ZERO) begin
                st_d.res = op_a;
            end else if (cancel) begin
                st_d.res = '0;
            end else begin
                st_d.res = rnd_word;
                st_d.ovf = rnd_ovf;
            end
        end else begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result = st_q.res;
    assign valid  = st_q.vld;
    assign ovf    = st_q.ovf;
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int TOT   = 1 + EXP_W + FRAC_W
) (
    input logic           clk,
    input logic           rst,
    input logic           en,
    input logic           sub,
    input logic [TOT-1:0] op_a,
    input logic [TOT-1:0] op_b,
    input logic [TOT-1:0] result,
    input logic           valid,
    input logic           ovf
);
    localparam logic [TOT-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, a_zero, b_norm;
    assign a_nan  = (&op_a[TOT-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
    assign a_zero = (op_a[TOT-2:FRAC_W] == '0);
    assign b_norm = (op_b[TOT-2:FRAC_W] != '0) && !(&op_b[TOT-2:FRAC_W]);

    p_qnan_r5: assert property (@(posedge clk) disable iff (rst)
        en && a_nan |=> result == QNAN);

    p_ovf_inf_r6: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (&result[TOT-2:FRAC_W]) && (result[FRAC_W-1:0] == '0));

    p_zero_pass_r7: assert property (@(posedge clk) disable iff (rst)
        en && a_zero && b_norm |=>
            result == $past({op_b[TOT-1] ^ sub, op_b[TOT-2:0]}));

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        en |=> valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(result) && $stable(ovf) && !valid);

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (result == '0) && !valid && !ovf);
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .sub(sub), .op_a(op_a), .op_b(op_b),
    .result(result), .valid(valid), .ovf(ovf)
);

// File: tb/fp_addsub_test.sv
`timescale 1ns/1ps
module fp_addsub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        sub = 1'b0;
    logic [63:0] a64 = '0, b64 = '0;
    logic [63:0] r64;
    logic        v64, o64;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [7:0]  r8;
    logic        v8, o8;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_addsub uut (
        .clk(clk), .rst(rst), .en(en), .sub(sub), .op_a(a64), .op_b(b64),
        .result(r64), .valid(v64), .ovf(o64)
    );

    fp_addsub #(.EXP_W(4), .FRAC_W(3)) uut_mini (
        .clk(clk), .rst(rst), .en(en), .sub(sub), .op_a(a8), .op_b(b8),
        .result(r8), .valid(v8), .ovf(o8)
    );

    task automatic check(input string tag, input logic [64:0] got,
                         input logic [64:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // exact model of the mini format: returns {ovf, word}
    function automatic logic [8:0] mref(input logic [7:0] a, input logic [7:0] b,
                                        input logic s);
        logic [7:0] be;
        logic       sa, sb, sg;
        int         ea, eb, fa, fb, p, e, sh;
        longint     va, vb, sm, m, q, rem, half;
        be = {b[7] ^ s, b[6:0]};
        sa = a[7]; sb = be[7];
        ea = int'(a[6:3]); eb = int'(be[6:3]);
        fa = int'(a[2:0]); fb = int'(be[2:0]);
        if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) return 9'h07C;
        if (ea == 15 && eb == 15) return (sa != sb) ? 9'h07C : {1'b0, a};
        if (ea == 15) return {1'b0, a};
        if (eb == 15) return {1'b0, be};
        if (ea == 0 && eb == 0) return {1'b0, sa & sb, 7'b0};
        if (ea == 0) return {1'b0, be};
        if (eb == 0) return {1'b0, a};
        va = longint'(8 + fa) <<< (ea - 1);
        vb = longint'(8 + fb) <<< (eb - 1);
        if (sa) va = -va;
        if (sb) vb = -vb;
        sm = va + vb;
        if (sm == 0) return 9'h000;
        sg = (sm < 0);
        m  = sg ? -sm : sm;
        p  = 0;
        for (int i = 0; i < 40; i++) if (m[i]) p = i;
        e = p - 2;
        if (p > 3) begin
            sh   = p - 3;
            q    = m >>> sh;
            rem  = m & ((longint'(1) <<< sh) - 1);
            half = longint'(1) <<< (sh - 1);
            if (rem > half || (rem == half && q[0])) q = q + 1;
            if (q == 16) begin q = 8; e = e + 1; end
        end else begin
            q = m <<< (3 - p);
        end
        if (e < 1)   return {1'b0, sg, 7'b0};
        if (e >= 15) return {1'b1, sg, 4'hF, 3'b0};
        return {1'b0, sg, 4'(e), q[2:0]};
    endfunction

    function automatic string mtag(input logic [7:0] a, input logic [7:0] b,
                                   input logic s, input logic [8:0] ex);
        if (&a[6:3] || &b[6:3]) return (a[2:0] != 0 || b[2:0] != 0) ? "R5" : "R6";
        if (ex[8]) return "R6";
        if (a[6:3] == 0 || b[6:3] == 0) return "R7";
        if (ex[6:3] == 0 && ex[7:0] != 0) return "R8";
        return ((a[7] ^ b[7] ^ s) != 1'b0) ? "R2" : "R1";
    endfunction

    task automatic run64(input logic [63:0] a, input logic [63:0] b, input logic s,
                         input logic [63:0] exp, input logic exp_ovf,
                         input string tag);
        @(negedge clk);
        a64 = a; b64 = b; sub = s; en = 1'b1;
        @(posedge clk); #1;
        check(tag, {o64, r64}, {exp_ovf, exp});
        check({tag, " valid"}, {64'b0, v64}, 65'd1);
    endtask

    localparam logic [63:0] DMAX = 64'h7FEF_FFFF_FFFF_FFFF;
    localparam logic [63:0] DINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
        end
    end

    initial begin : stim
        real x, y;
        repeat (2) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 reset result", {o64, r64}, 65'd0);
        check("R10 reset valid", {64'b0, v64}, 65'd0);
        @(negedge clk); rst = 1'b0;

        // R1 additions
        x = 1.5; y = 2.25;
        run64($realtobits(x), $realtobits(y), 1'b0, $realtobits(x + y), 1'b0, "R1 small sum");
        x = 0.1; y = 0.2;
        run64($realtobits(x), $realtobits(y), 1'b0, $realtobits(x + y), 1'b0, "R1 inexact sum");
        x = -3.14159; y = -271.828;
        run64($realtobits(x), $realtobits(y), 1'b0, $realtobits(x + y), 1'b0, "R1 negative sum");
        // R2 subtractions
        x = 1.0; y = 3.0;
        run64($realtobits(x), $realtobits(y), 1'b1, $realtobits(x - y), 1'b0, "R2 sign flip");
        x = 5.5;
        run64($realtobits(x), $realtobits(x), 1'b1, 64'h0, 1'b0, "R2 cancel to +0");
        x = 1.0000001; y = 1.0;
        run64($realtobits(x), $realtobits(y), 1'b1, $realtobits(x - y), 1'b0, "R2 deep cancel");
        // R3 alignment
        x = 1.0; y = 1.0e-30;
        run64($realtobits(x), $realtobits(y), 1'b0, $realtobits(x), 1'b0, "R3 huge gap");
        run64(64'h3FF0_0000_0000_0000, 64'h3CA0_0000_0000_0000, 1'b0,
              64'h3FF0_0000_0000_0000, 1'b0, "R3 exact tie to even");
        run64(64'h3FF0_0000_0000_0000, 64'h3CA0_0000_0000_0001, 1'b0,
              64'h3FF0_0000_0000_0001, 1'b0, "R3 sticky breaks tie");
        run64(64'h3FF0_0000_0000_0000, 64'h3CA0_0000_0000_0001, 1'b1,
              64'h3FEF_FFFF_FFFF_FFFF, 1'b0, "R3 sticky on subtract");
        // R4 carry
        x = 1.5; y = 1.75;
        run64($realtobits(x), $realtobits(y), 1'b0, $realtobits(x + y), 1'b0, "R4 carry");
        run64(64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0,
              64'h4000_0000_0000_0000, 1'b0, "R4 dropped bit tie");
        run64(64'h3FF0_0000_0000_0003, 64'h3FF0_0000_0000_0000, 1'b0,
              64'h4000_0000_0000_0002, 1'b0, "R4 dropped bit round up");
        // R5 / R6
        run64(DINF, DINF, 1'b1, DNAN, 1'b0, "R5 inf minus inf");
        run64(64'h7FF0_0000_0000_0123, 64'h3FF0_0000_0000_0000, 1'b0, DNAN, 1'b0, "R5 nan in");
        run64(DMAX, DMAX, 1'b0, DINF, 1'b1, "R6 overflow");
        run64(64'h3FF0_0000_0000_0000, DINF, 1'b1, 64'hFFF0_0000_0000_0000, 1'b0, "R6 inf pass");
        // R7
        run64(64'h0000_0000_0000_0005, 64'h4000_0000_0000_0000, 1'b1,
              64'hC000_0000_0000_0000, 1'b0, "R7 subnormal as zero");

        // R9: hold with en low
        @(negedge clk);
        en = 1'b0; a64 = 64'h4010_0000_0000_0000; a8 = 8'h40;
        @(posedge clk); #1;
        check("R9 hold result", {o64, r64}, {1'b0, 64'hC000_0000_0000_0000});
        check("R9 valid low", {64'b0, v64}, 65'd0);
        // R10 mid-run reset
        run64(DMAX, DMAX, 1'b0, DINF, 1'b1, "R6 overflow again");
        @(negedge clk); rst = 1'b1; en = 1'b1;
        @(posedge clk); #1;
        check("R10 mid reset", {v64, o64, r64[62:0]}, 65'd0);
        @(negedge clk); rst = 1'b0;

        // sweep of the mini format
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int is = 0; is < 2; is++) begin
                    logic [8:0] ex;
                    @(negedge clk);
                    a8 = 8'(ia); b8 = 8'(ib); sub = 1'(is); en = 1'b1;
                    ex = mref(8'(ia), 8'(ib), 1'(is));
                    @(posedge clk); #1;
                    check($sformatf("%s mini a=%h b=%h s=%0d", mtag(8'(ia), 8'(ib), 1'(is), ex),
                                    ia, ib, is),
                          {55'b0, v8, o8, r8}, {55'b0, 1'b1, ex});
                end
            end
        end
        done = 1'b1;
        summary();
    end
endmodule